// File: doc/BRIEF.md
# Circular-Buffer Pixel Fetch and Unpack

This block sits behind a raster timing generator. In the display phase it reads bytes from a video memory through a synchronous read port, at an address that runs through a programmable circular buffer. It splits each byte into palette indices according to the selected colour depth, looks each index up in a 16-entry palette of 12-bit colours, and emits one colour per clock with a valid strobe. The timing generator supplies a half-pixel enable, which is asserted in at most every other cycle, together with the current raster phase, a line-start pulse and a frame-start pulse.

Each display enable produces two pixels. The depth sets how often a byte is fetched and which bits of the byte feed each pixel. A small two-entry pixel buffer spreads the pair over two consecutive cycles. Outside the display phase no memory is read. The idle output is the border colour in the border phase and zero in any other phase.

Top module: `pix_fetch_unpack`

## Requirements
- R1: While reset is asserted and just after it, mem_rd_o and pix_valid_o are 0 and mem_addr_o is 0.
- R2: Each cycle with mem_rd_o high advances the address by one. When the incremented value equals buf_end_i, the address loads buf_start_i instead.
- R3: frame_start_i loads frame_base_i into the address and takes priority over the advance from a read in the same cycle. That read still uses the old address.
- R4: Depth code 2 (4 bpp) reads one byte per display enable. The pair is palette[byte[3:0]] followed by palette[byte[7:4]].
- R5: Depth code 1 (2 bpp) reads a byte only on enables with an even line count. An even enable outputs fields [1:0] then [3:2] of that byte. An odd enable outputs [5:4] then [7:6] of the same byte.
- R6: Depth code 0 (1 bpp) reads a byte only when the line count mod 4 is 0. An enable with count mod 4 = k outputs bit 2k, then bit 2k+1.
- R7: Depth code 3 (8 bpp) reads two bytes, one in the enable cycle and one in the next. The pair is palette[first[3:0]] followed by palette[second[3:0]].
- R8: The line count counts display enables. line_start_i clears it, and an enable in the same cycle sees a count of 0.
- R9: An enable in cycle t gives valid pixels in cycles t+3 and t+4, in the order stated for its depth. Palette entry k is palette_i[12k+11:12k]. No valid pixel appears otherwise.
- R10: A half-pixel enable outside the display phase (phase_i other than 3) causes no read, does not advance the line count and yields no pixel.
- R11: While pix_valid_o is 0, pix_o equals border_i when phase_i is 2 (border) and zero in the sync (0) and blank (1) phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_en_i | input | 1 | Half-pixel enable, at most every other cycle |
| phase_i | input | 2 | Raster phase: 0 sync, 1 blank, 2 border, 3 display |
| depth_i | input | 2 | Colour depth: 0 1bpp, 1 2bpp, 2 4bpp, 3 8bpp |
| line_start_i | input | 1 | Clears the line pixel count |
| frame_start_i | input | 1 | Reloads the address from frame_base_i |
| frame_base_i | input | AW | Frame start address |
| buf_start_i | input | AW | Circular buffer start |
| buf_end_i | input | AW | Circular buffer end (wrap compare value) |
| palette_i | input | 16*CW | Packed palette, entry k at bits 12k+11:12k |
| border_i | input | CW | Border colour |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | AW | Memory read address |
| mem_data_i | input | 8 | Read data, one cycle after the strobe |
| pix_o | output | CW | Pixel colour |
| pix_valid_o | output | 1 | Pixel valid strobe |

## Verification
A frame-start reload can fall in the same cycle as a fetch's address advance. In 8 bpp it can also fall in the cycle before the second read. The bench pulses frame start together with a display enable at 4 bpp and at 8 bpp, then checks every strobed address and every pixel. The first read must use the old address, and everything after it must come from the frame base. A line-start pulse is also made to coincide with a 1 bpp enable at a nonzero count. That enable must fetch a fresh byte and output bits 0 and 1.

// File: rtl/pfu_pkg.sv
package pfu_pkg;
  localparam int BYTE_W = 8;
  localparam int PAL_N  = 16;
  localparam int IDX_W  = $clog2(PAL_N);

  typedef enum logic [1:0] {
    PH_SYNC   = 2'd0,
    PH_BLANK  = 2'd1,
    PH_BORDER = 2'd2,
    PH_DISP   = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    DP_1 = 2'd0,
    DP_2 = 2'd1,
    DP_4 = 2'd2,
    DP_8 = 2'd3
  } depth_e;

  // one display enable travelling down the pipe
  typedef struct packed {
    logic       vld;
    logic       fetched;
    depth_e     depth;
    logic [1:0] sel;
  } slot_t;
endpackage

// File: rtl/pfu_addr_gen.sv
module pfu_addr_gen #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic          frame_i,
  input  logic [AW-1:0] frame_base_i,
  input  logic [AW-1:0] buf_start_i,
  input  logic [AW-1:0] buf_end_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] addr_q, inc, nxt;

  always_comb begin
    inc = addr_q + ONE;
    nxt = addr_q;
    if (frame_i)   nxt = frame_base_i;
    else if (rd_i) nxt = (inc == buf_end_i) ? buf_start_i : inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= nxt;
  end

  assign addr_o = addr_q;

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !frame_i && (addr_q + ONE != buf_end_i)) |=> (addr_q == $past(addr_q) + ONE));
  a_r2_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !frame_i && (addr_q + ONE == buf_end_i)) |=> (addr_q == $past(buf_start_i)));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !frame_i) |=> $stable(addr_q));
  a_r3_frame_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> (addr_q == $past(frame_base_i)));
endmodule

// File: rtl/pfu_fetch_ctrl.sv
module pfu_fetch_ctrl
  import pfu_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       half_en_i,
  input  logic [1:0] phase_i,
  input  logic [1:0] depth_i,
  input  logic       line_start_i,
  output logic       rd_o,
  output slot_t      slot_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  phase_e           ph;
  depth_e           dp;
  logic             en, fetch, second_q;
  logic [CNT_W-1:0] cnt_q, cnt_use;
  slot_t            slot_q;

  assign ph      = phase_e'(phase_i);
  assign dp      = depth_e'(depth_i);
  assign en      = half_en_i && (ph == PH_DISP);
  assign cnt_use = line_start_i ? '0 : cnt_q;

  always_comb begin
    unique case (dp)
      DP_1:    fetch = en && (cnt_use[1:0] == 2'b00);
      DP_2:    fetch = en && !cnt_use[0];
      default: fetch = en;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      second_q <= 1'b0;
      slot_q   <= '0;
    end else begin
      cnt_q          <= en ? cnt_use + ONE : cnt_use;
      second_q       <= en && (dp == DP_8);
      slot_q.vld     <= en;
      slot_q.fetched <= fetch;
      slot_q.depth   <= dp;
      slot_q.sel     <= cnt_use[1:0];
    end
  end

  assign rd_o   = fetch | second_q;
  assign slot_o = slot_q;

  a_r7_second_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && dp == DP_8) |=> rd_o);
  a_r10_no_idle_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> (en || $past(en && dp == DP_8)));
  a_r8_line_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_i && en) |-> rd_o);
endmodule

// File: rtl/pfu_unpack.sv
module pfu_unpack
  import pfu_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  slot_t                 slot_i,
  input  logic [BYTE_W-1:0]     mem_data_i,
  input  logic [PAL_N*CW-1:0]   palette_i,
  output logic [CW-1:0]         pix_o,
  output logic                  pix_valid_o
);
  slot_t             s2_q;
  logic [BYTE_W-1:0] hold_q;
  logic [IDX_W-1:0]  i0, i1;
  logic [CW-1:0]     pal [PAL_N];
  logic [CW-1:0]     head_q, tail_q;
  logic [1:0]        left_q;

  for (genvar g = 0; g < PAL_N; g++) begin : g_pal
    assign pal[g] = palette_i[g*CW +: CW];
  end

  // hold_q is the first byte, mem_data_i the second one in 8 bpp
  always_comb begin
    unique case (s2_q.depth)
      DP_1: begin
        i0 = {{(IDX_W-1){1'b0}}, hold_q[{s2_q.sel, 1'b0}]};
        i1 = {{(IDX_W-1){1'b0}}, hold_q[{s2_q.sel, 1'b1}]};
      end
      DP_2: begin
        i0 = {2'b00, s2_q.sel[0] ? hold_q[5:4] : hold_q[1:0]};
        i1 = {2'b00, s2_q.sel[0] ? hold_q[7:6] : hold_q[3:2]};
      end
      DP_4: begin
        i0 = hold_q[3:0];
        i1 = hold_q[7:4];
      end
      default: begin
        i0 = hold_q[3:0];
        i1 = mem_data_i[3:0];
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_q   <= '0;
      hold_q <= '0;
      head_q <= '0;
      tail_q <= '0;
      left_q <= '0;
    end else begin
      s2_q <= slot_i;
      if (slot_i.vld && slot_i.fetched) hold_q <= mem_data_i;
      if (s2_q.vld) begin
        head_q <= pal[i0];
        tail_q <= pal[i1];
        left_q <= 2'd2;
      end else if (left_q != 2'd0) begin
        head_q <= tail_q;
        left_q <= left_q - 2'd1;
      end
    end
  end

  assign pix_o       = head_q;
  assign pix_valid_o = (left_q != 2'd0);

  a_r9_two_pixels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pix_valid_o) |=> pix_valid_o);
  a_r9_load_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_q.vld |=> pix_valid_o);
endmodule

// File: rtl/pix_fetch_unpack.sv
module pix_fetch_unpack
  import pfu_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CW    = 12,
  parameter int CNT_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                half_en_i,
  input  logic [1:0]          phase_i,
  input  logic [1:0]          depth_i,
  input  logic                line_start_i,
  input  logic                frame_start_i,
  input  logic [AW-1:0]       frame_base_i,
  input  logic [AW-1:0]       buf_start_i,
  input  logic [AW-1:0]       buf_end_i,
  input  logic [16*CW-1:0]    palette_i,
  input  logic [CW-1:0]       border_i,
  output logic                mem_rd_o,
  output logic [AW-1:0]       mem_addr_o,
  input  logic [7:0]          mem_data_i,
  output logic [CW-1:0]       pix_o,
  output logic                pix_valid_o
);
  slot_t         slot;
  logic          rd;
  logic [CW-1:0] pix_q;
  logic          vld_q;

  pfu_fetch_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk_i, .rst_ni, .half_en_i, .phase_i, .depth_i, .line_start_i,
    .rd_o(rd), .slot_o(slot)
  );

  pfu_addr_gen #(.AW(AW)) i_addr (
    .clk_i, .rst_ni, .rd_i(rd), .frame_i(frame_start_i),
    .frame_base_i, .buf_start_i, .buf_end_i, .addr_o(mem_addr_o)
  );

  pfu_unpack #(.CW(CW)) i_unp (
    .clk_i, .rst_ni, .slot_i(slot), .mem_data_i, .palette_i,
    .pix_o(pix_q), .pix_valid_o(vld_q)
  );

  assign mem_rd_o    = rd;
  assign pix_valid_o = vld_q;
  assign pix_o       = vld_q ? pix_q
                     : (phase_e'(phase_i) == PH_BORDER) ? border_i : '0;

  a_r9_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_en_i && phase_i == 2'd3) |-> ##3 pix_valid_o);
  a_r10_blank_no_pix: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_en_i && phase_i != 2'd3) |-> !mem_rd_o || $past(half_en_i && phase_i == 2'd3 && depth_i == 2'd3));
endmodule

// File: tb/test_pix_fetch_unpack.sv
`timescale 1ns/1ps
module test_pix_fetch_unpack;
  localparam int AW = 16;
  localparam int CW = 12;

  typedef struct {
    logic [CW-1:0] c;
    int            cy;
    string         req;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic half_en = 0, line_start = 0, frame_start = 0;
  logic [1:0] phase = 2'd1, depth = 2'd2;
  logic [AW-1:0] frame_base = '0, buf_start = '0, buf_end = '0;
  logic [16*CW-1:0] palette;
  logic [CW-1:0] border = 12'h5A3;
  logic mem_rd, pix_valid;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_data = '0;
  logic [CW-1:0] pix;

  int checks = 0, errors = 0, cyc = 0, rd_cnt = 0;
  bit mon_on = 0, done = 0;
  exp_t pq[$];
  logic [AW-1:0] aq[$];
  logic [AW-1:0] maddr;
  int mcnt;
  logic [7:0] hold_m;

  pix_fetch_unpack i_pix_fetch_unpack (
    .clk_i(clk), .rst_ni(rst_n), .half_en_i(half_en), .phase_i(phase),
    .depth_i(depth), .line_start_i(line_start), .frame_start_i(frame_start),
    .frame_base_i(frame_base), .buf_start_i(buf_start), .buf_end_i(buf_end),
    .palette_i(palette), .border_i(border), .mem_rd_o(mem_rd),
    .mem_addr_o(mem_addr), .mem_data_i(mem_data), .pix_o(pix),
    .pix_valid_o(pix_valid)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  function automatic logic [7:0] mb(input logic [AW-1:0] a);
    return 8'(a[7:0] * 8'd37 + 8'd11);
  endfunction

  function automatic logic [CW-1:0] pal(input logic [3:0] k);
    return {k, ~k, k ^ 4'hA};
  endfunction

  always @(posedge clk) if (mem_rd) mem_data <= mb(mem_addr);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: address strobes and pixel stream
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (mem_rd) begin
        rd_cnt++;
        if (aq.size() == 0) chk(0, "R10 unexpected read", int'(mem_addr), -1);
        else begin
          chk(mem_addr == aq[0], "R2/R3 read address", int'(mem_addr), int'(aq[0]));
          void'(aq.pop_front());
        end
      end
      if (pq.size() > 0 && pq[0].cy == cyc) begin
        chk(pix_valid && pix == pq[0].c, pq[0].req, int'({pix_valid, pix}), int'({1'b1, pq[0].c}));
        void'(pq.pop_front());
      end else if (pix_valid) begin
        chk(0, "R9 unexpected valid", int'(pix), -1);
      end
    end
  end

  function automatic void adv();
    maddr = (maddr + 1'b1 == buf_end) ? buf_start : AW'(maddr + 1'b1);
  endfunction

  task automatic do_en(input bit fs, input bit ls);
    int used;
    bit f;
    logic [7:0] b;
    logic [3:0] i0, i1;
    string req;
    half_en = 1; frame_start = fs; line_start = ls; phase = 2'd3;
    used = ls ? 0 : mcnt;
    case (depth)
      2'd0: f = (used % 4) == 0;
      2'd1: f = (used % 2) == 0;
      default: f = 1;
    endcase
    if (f) begin
      aq.push_back(maddr); hold_m = mb(maddr); adv();
    end
    if (fs) maddr = frame_base;
    b = 8'h00;
    if (depth == 2'd3) begin
      aq.push_back(maddr); b = mb(maddr); adv();
    end
    case (depth)
      2'd0: begin i0 = {3'b0, hold_m[2*(used%4)]}; i1 = {3'b0, hold_m[2*(used%4)+1]}; req = "R6 1bpp pixel"; end
      2'd1: begin
        if (used % 2 == 0) begin i0 = {2'b0, hold_m[1:0]}; i1 = {2'b0, hold_m[3:2]}; end
        else               begin i0 = {2'b0, hold_m[5:4]}; i1 = {2'b0, hold_m[7:6]}; end
        req = "R5 2bpp pixel";
      end
      2'd2: begin i0 = hold_m[3:0]; i1 = hold_m[7:4]; req = "R4 4bpp pixel"; end
      default: begin i0 = hold_m[3:0]; i1 = b[3:0]; req = "R7 8bpp pixel"; end
    endcase
    if (ls) req = {req, " R8"};
    if (fs) req = {req, " R3"};
    pq.push_back('{c: pal(i0), cy: cyc + 3, req: req});
    pq.push_back('{c: pal(i1), cy: cyc + 4, req: req});
    mcnt = used + 1;
    @(posedge clk); #1;
    half_en = 0; frame_start = 0; line_start = 0;
    @(posedge clk); #1;
  endtask

  task automatic pulse_frame();
    frame_start = 1; @(posedge clk); #1; frame_start = 0;
    maddr = frame_base;
  endtask

  task automatic pulse_line();
    line_start = 1; @(posedge clk); #1; line_start = 0;
    mcnt = 0;
  endtask

  task automatic drain();
    phase = 2'd2;
    repeat (8) @(posedge clk); #1;
  endtask

  initial begin
    for (int k = 0; k < 16; k++) palette[k*CW +: CW] = pal(4'(k));
    maddr = '0; mcnt = 0; hold_m = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mem_rd == 0 && pix_valid == 0 && mem_addr == 0, "R1 in reset",
        int'({mem_rd, pix_valid, mem_addr}), 0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk(mem_rd == 0 && pix_valid == 0, "R1 after reset", int'({mem_rd, pix_valid}), 0);
    chk(mem_addr == 0, "R1 address", int'(mem_addr), 0);
    mon_on = 1;
    @(posedge clk); #1;

    buf_start = 16'h0020; buf_end = 16'h0028; frame_base = 16'h0024;
    pulse_frame();
    depth = 2'd2; pulse_line();
    for (int i = 0; i < 10; i++) do_en(0, 0);        // R4 + R2 wrap
    depth = 2'd1; pulse_line();
    for (int i = 0; i < 9; i++) do_en(0, 0);         // R5
    // R10: enables outside display have no effect
    begin
      int r0;
      drain();
      r0 = rd_cnt;
      phase = 2'd1;
      for (int i = 0; i < 3; i++) begin
        half_en = 1; @(posedge clk); #1; half_en = 0; @(posedge clk); #1;
      end
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(rd_cnt == r0 && !pix_valid, "R10 no read in blank", rd_cnt - r0, 0);
      @(posedge clk); #1;
    end
    for (int i = 0; i < 3; i++) do_en(0, 0);         // count continues odd
    depth = 2'd0; pulse_line();
    for (int i = 0; i < 10; i++) do_en(0, 0);        // R6
    do_en(0, 1);                                     // R8: line start with enable
    do_en(0, 0);
    depth = 2'd3; pulse_line();
    for (int i = 0; i < 8; i++) do_en(0, 0);         // R7 wraps
    frame_base = 16'h0022;
    depth = 2'd2;
    do_en(1, 0);                                     // R3 with 4bpp read
    do_en(0, 0);
    frame_base = 16'h0026;
    depth = 2'd3;
    do_en(1, 0);                                     // R3 with 8bpp reads
    do_en(0, 0); do_en(0, 0);
    drain();
    chk(pq.size() == 0 && aq.size() == 0, "R9 all pixels seen", pq.size() + aq.size(), 0);

    @(negedge clk);
    chk(!pix_valid && pix == border, "R11 border idle", int'(pix), int'(border));
    @(posedge clk); #1 phase = 2'd0;
    @(negedge clk);
    chk(pix == 0, "R11 sync idle", int'(pix), 0);
    @(posedge clk); #1 phase = 2'd1;
    @(negedge clk);
    chk(pix == 0, "R11 blank idle", int'(pix), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule